// File: doc/BRIEF.md
# Serial Status Flag Register

This block holds the status word of a synchronous serial unit as it appears on a processor bus. It keeps four flags: transmit buffer empty, receive buffer full, transmit underrun and receive overrun. The transmit and receive datapaths report single-cycle event strobes: data written for transmit, transfer started, reception finished, received data taken. The block turns these strobes into flag updates and raises the two error flags when a transfer starts with nothing to send or a reception lands on unread data.

Software clears a flag by writing 0 to it, but only after a bus read returned that flag as 1. Each flag therefore carries a hidden armed bit. The armed bit is set by a read that sees the flag high. It is used up by the write that clears the flag. An interrupt request is the OR of the four flags, each gated by its own enable.

Top module: `ser_stat_reg`

## Requirements
- R1: After reset the register reads 0x0002: transmit-empty (bit 1) is 1 and every other bit is 0.
- R2: Bits 15 down to 4 always read 0, and writing 1s to them changes nothing.
- R3: The transmit underrun flag (bit 3) becomes 1 in the cycle after a transfer-start strobe that arrives while transmit-empty is 1.
- R4: The receive overrun flag (bit 2) becomes 1 in the cycle after a reception-done strobe that arrives while receive-full (bit 0) is 1.
- R5: A write with 0 in a flag bit clears that flag only if an earlier read, after the last clear of it, returned the flag as 1. A write of 0 with no such read leaves the flag unchanged.
- R6: A write of 1 to a flag bit leaves the flag unchanged. A clear uses up the armed state, so a later write of 0 clears the flag only after a fresh read shows it as 1.
- R7: When a set event and a valid software clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R8: A transmit-data write strobe clears transmit-empty and a transfer-start strobe sets it. A reception-done strobe sets receive-full and a receive-data-read strobe clears it. Where a set and a clear meet in one cycle, the set wins.
- R9: irq equals the OR over bits 3..0 of flag AND irq_en, in the same cycle (default variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe for the register; arms the flags that read 1 |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register value |
| tx_wr_ev | input | 1 | Transmit data written by software |
| tx_start_ev | input | 1 | Transmit transfer starts, data moved to the shifter |
| rx_done_ev | input | 1 | Reception finished |
| rx_rd_ev | input | 1 | Received data taken by software |
| irq_en | input | 4 | Per-flag interrupt enables, same bit order as the flags |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover each flag transition on its own. They include a write of 0 with no read before it, which must leave the flag set, and a write of 1 after a read, which must also leave it set. They also include a repeat clear after the armed state was used up, and a clear that meets a set event in the same cycle. These separate a design that clears on any write of 0 from one that honours the read-then-write rule, and they show the set-over-clear priority. Constrained random cycles then mix every strobe with reads and writes at high density. This brings out event pairs in one cycle and overrun or underrun chains that the directed cases do not reach. Each cycle is compared with a bench model of the register and the interrupt.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int NFLAG   = 4;
   localparam int B_TUR   = 3;   // transmit underrun
   localparam int B_ROV   = 2;   // receive overrun
   localparam int B_TDE   = 1;   // transmit buffer empty
   localparam int B_RDF   = 0;   // receive buffer full
   localparam logic [NFLAG-1:0] FLAG_RST = 4'b0010;
endpackage

// File: rtl/ssr_evt.sv
// Turns datapath strobes and current flags into per-flag set/clear requests.
module ssr_evt
   import ssr_pkg::*;
(
   input  logic [NFLAG-1:0] flags_i,
   input  logic             tx_wr_i,
   input  logic             tx_start_i,
   input  logic             rx_done_i,
   input  logic             rx_rd_i,
   output logic [NFLAG-1:0] set_o,
   output logic [NFLAG-1:0] clr_o
);
   always_comb begin
      set_o        = '0;
      clr_o        = '0;
      set_o[B_TUR] = tx_start_i & flags_i[B_TDE];
      set_o[B_ROV] = rx_done_i  & flags_i[B_RDF];
      set_o[B_TDE] = tx_start_i;
      clr_o[B_TDE] = tx_wr_i;
      set_o[B_RDF] = rx_done_i;
      clr_o[B_RDF] = rx_rd_i;
   end
endmodule

// File: rtl/ssr_flag_cell.sv
// One status flag with its read-as-1 armed bit.
module ssr_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic evclr_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o
);
   logic flag_q, arm_q;
   logic sw_clr;

   assign sw_clr = wr_i & ~wbit_i & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= RST_VAL;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= set_i | (flag_q & ~(sw_clr | evclr_i));
         if (sw_clr)
            arm_q <= 1'b0;
         else if (rd_i && flag_q)
            arm_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
   import ssr_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tx_wr_ev,
   input  logic              tx_start_ev,
   input  logic              rx_done_ev,
   input  logic              rx_rd_ev,
   input  logic [NFLAG-1:0]  irq_en,
   output logic              irq
);
   localparam int PAD_W = DATA_W - NFLAG;

   generate
      if (DATA_W < NFLAG + 1) begin : g_bad_width
         $error("ser_stat_reg: DATA_W must exceed the flag count");
      end
   endgenerate

   logic [NFLAG-1:0] flags, set_v, clr_v;

   ssr_evt u_evt (
      .flags_i    (flags),
      .tx_wr_i    (tx_wr_ev),
      .tx_start_i (tx_start_ev),
      .rx_done_i  (rx_done_ev),
      .rx_rd_i    (rx_rd_ev),
      .set_o      (set_v),
      .clr_o      (clr_v)
   );

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         ssr_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_v[i]),
            .evclr_i (clr_v[i]),
            .rd_i    (bus_rd),
            .wr_i    (bus_wr),
            .wbit_i  (bus_wdata[i]),
            .flag_o  (flags[i])
         );
      end
   endgenerate

   assign bus_rdata = {{PAD_W{1'b0}}, flags};

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(flags & irq_en);
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |(flags & irq_en);
      end
   endgenerate
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
   parameter int DATA_W  = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              tx_wr_ev,
   input logic              tx_start_ev,
   input logic              rx_done_ev,
   input logic              rx_rd_ev,
   input logic [3:0]        irq_en,
   input logic              irq
);
   a_r1_reset_value: assert property (@(posedge clk)
      !rst_n |=> bus_rdata == 16'h0002);

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (bus_wdata[DATA_W-1:4] != '0) |=> bus_rdata[DATA_W-1:4] == '0);

   a_r3_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_ev && bus_rdata[1] |=> bus_rdata[3]);

   a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_ev && bus_rdata[0] |=> bus_rdata[2]);

   a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_wdata[3] && bus_rdata[3] |=> bus_rdata[3]);

   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_ev |=> bus_rdata[0]);

   a_r8_tx_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_ev && !tx_start_ev |=> !bus_rdata[1]);

   generate
      if (IRQ_REG) begin : g_r
         a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> irq == |($past(bus_rdata[3:0]) & $past(irq_en)));
      end else begin : g_c
         a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(bus_rdata[3:0] & irq_en));
      end
   endgenerate
endmodule

bind ser_stat_reg ssr_chk #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_wr_ev(tx_wr_ev),
   .tx_start_ev(tx_start_ev), .rx_done_ev(rx_done_ev), .rx_rd_ev(rx_rd_ev),
   .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_ser_stat_reg.sv
module tb_ser_stat_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 0, bus_wr = 0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tx_wr_ev = 0, tx_start_ev = 0, rx_done_ev = 0, rx_rd_ev = 0;
   logic [3:0]  irq_en = '0;
   logic        irq;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // model state: flags and armed bits
   logic [3:0] m_flag, m_arm;

   always #10 clk = ~clk;   // 50 MHz

   ser_stat_reg dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_wr_ev(tx_wr_ev),
      .tx_start_ev(tx_start_ev), .rx_done_ev(rx_done_ev), .rx_rd_ev(rx_rd_ev),
      .irq_en(irq_en), .irq(irq)
   );

   function automatic logic [3:0] nxt_flag(input logic [3:0] f, input logic [3:0] a,
         input logic wr, input logic [3:0] wd, input logic txw, input logic txs,
         input logic rxd, input logic rxr);
      logic [3:0] set, clr;
      set = {txs & f[1], rxd & f[0], txs, rxd};
      clr = (wr ? (~wd & a) : 4'b0) | {2'b00, txw, rxr};
      return set | (f & ~clr);
   endfunction

   function automatic logic [3:0] nxt_arm(input logic [3:0] f, input logic [3:0] a,
         input logic rd, input logic wr, input logic [3:0] wd);
      logic [3:0] used;
      used = wr ? (~wd & a) : 4'b0;
      return (a & ~used) | ((rd ? f : 4'b0) & ~used);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus/event cycle: drive at negedge, update model, check at next negedge
   task automatic cyc(input string req, input logic rd, input logic wr,
         input logic [15:0] wd, input logic txw, input logic txs,
         input logic rxd, input logic rxr);
      logic [3:0] nf, na;
      bus_rd = rd; bus_wr = wr; bus_wdata = wd;
      tx_wr_ev = txw; tx_start_ev = txs; rx_done_ev = rxd; rx_rd_ev = rxr;
      nf = nxt_flag(m_flag, m_arm, wr, wd[3:0], txw, txs, rxd, rxr);
      na = nxt_arm(m_flag, m_arm, rd, wr, wd[3:0]);
      @(posedge clk);
      m_flag = nf; m_arm = na;
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; bus_wdata = '0;
      tx_wr_ev = 0; tx_start_ev = 0; rx_done_ev = 0; rx_rd_ev = 0;
      check(req, bus_rdata, {12'h000, m_flag});
      check({req, " irq R9"}, {15'h0, irq}, {15'h0, |(m_flag & irq_en)});
   endtask

   initial begin
      m_flag = 4'b0010; m_arm = 4'b0000;
      repeat (3) @(negedge clk);
      check("R1 reset value", bus_rdata, 16'h0002);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", bus_rdata, 16'h0002);

      // R8 transmit empty handling
      cyc("R8 tx write clears empty", 0,0,16'h0, 1,0,0,0);
      cyc("R8 tx start sets empty",  0,0,16'h0, 0,1,0,0);
      // R3 underrun: start while empty
      cyc("R3 underrun set",         0,0,16'h0, 0,1,0,0);
      // R5 write 0 without read: no effect
      cyc("R5 clear without read",   0,1,16'h0, 0,0,0,0);
      // R6 read then write 1: no effect
      cyc("R6 read arms",            1,0,16'h0, 0,0,0,0);
      cyc("R6 write one keeps",      0,1,16'h000F, 0,0,0,0);
      // R5 armed write 0 clears underrun only
      cyc("R5 armed clear",          0,1,16'hFFF7, 0,0,0,0);
      // R6 armed used up: set again, write 0 without reread
      cyc("R3 underrun again",       0,0,16'h0, 0,1,0,0);
      cyc("R6 disarmed after clear", 0,1,16'hFFF7, 0,0,0,0);
      // R4 overrun
      cyc("R8 rx done sets full",    0,0,16'h0, 0,0,1,0);
      cyc("R4 overrun set",          0,0,16'h0, 0,0,1,0);
      cyc("R8 rx read clears full",  0,0,16'h0, 0,0,0,1);
      // R7 set wins over valid clear
      cyc("R7 rx done",              0,0,16'h0, 0,0,1,0);
      cyc("R7 read arms",            1,0,16'h0, 0,0,0,0);
      cyc("R7 set beats clear",      0,1,16'hFFF0, 0,0,1,0);
      // R2 reserved bits
      cyc("R2 reserved write",       1,1,16'hFFF0, 0,0,0,0);
      cyc("R2 reserved ones",        0,1,16'hFFFF, 0,0,0,0);
      // R9 irq enables
      irq_en = 4'b0100;
      cyc("R9 overrun enable",       0,0,16'h0, 0,0,0,0);
      irq_en = 4'b0001;
      cyc("R9 full enable",          0,0,16'h0, 0,0,0,1);

      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] wd;
         wd = $urandom();
         irq_en = $urandom_range(0, 15);
         cyc("random R3 R4 R5 R6 R7 R8",
             ($urandom_range(0,2) == 0), ($urandom_range(0,3) == 0), wd,
             ($urandom_range(0,4) == 0), ($urandom_range(0,4) == 0),
             ($urandom_range(0,3) == 0), ($urandom_range(0,4) == 0));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule